// File: doc/BRIEF.md
# Audio Serial Frame Timing Generator

This block is the master-mode timing source for a stereo or multi-slot (TDM) audio serial port. It runs on the master clock. It divides that clock down to a bit clock and drives a word-select / frame-sync line in one of four framing formats. It also gives a slot index and an MSB-launch strobe, which tell an attached serializer and deserializer where every sample begins.

Configuration is static while the clocks run. It consists of the format code, the slot count for TDM, the frame-sync shape, a slot-width select and a 6-bit oversampling code. Software starts the clocks with a one-cycle `clk_on` pulse and stops them with a one-cycle `clk_off` pulse. After a stop request the block finishes the current frame and then parks. A `soft_rst` pulse returns the block to idle at once. A configuration that cannot be divided evenly raises `cfg_err`, and while it is raised a start request is refused.

Top module: `aud_frame_timer`

## Requirements
- R1: After reset, and whenever `active` is low, `bclk` and `msb_strobe` are 0 and `slot_idx` is 0. `wsel` rests at 1 when `cfg_fmt` is 0 and at 0 for the other format codes.
- R2: One bit period lasts D = (cfg_ratio+1)*16/W master clocks, where W is the slot width. Within each bit period `bclk` is low for the first D - floor(D/2) clocks and high for the remaining floor(D/2).
- R3: `cfg_slot_sel` = 0 gives slots of W = 32 bit periods, and 1 gives W = 24.
- R4: Format codes 0 and 1 always use 2 slots, whatever `cfg_chan_m1` holds. Codes 2 and 3 use `cfg_chan_m1`+1 slots. `slot_idx` counts 0 up to slots-1 and then wraps.
- R5: Format code 0 drives `wsel` low in slot 0 and high in every other slot. `msb_strobe` pulses for one master clock at the start of bit 1 of each slot.
- R6: Format code 1 drives `wsel` high in slot 0 and low in every other slot. `msb_strobe` pulses at the start of bit 0 of each slot.
- R7: Format codes 2 and 3 raise `wsel` at the start of slot 0. `cfg_sync_shape` sets how long it stays high. Code 0 holds it for one slot. Code 1 holds it for max(1, floor(slots/2)) slots. Code 2 holds it for one bit period. `msb_strobe` marks bit 1 of each slot for format 2 and bit 0 for format 3.
- R8: `cfg_err` is 1 in three cases: (cfg_ratio+1)*16 is not a multiple of W, D < 2, or a TDM format is set with `cfg_sync_shape` = 3. While it is 1, `clk_on` is ignored and `active` stays 0.
- R9: When `clk_on` is seen while the block is idle, the next master clock is the first clock of bit 0 of slot 0. A `clk_on` seen while the block is running has no effect.
- R10: A `clk_off` seen while the block is running lets the current frame finish. `active` then falls on the clock after the last clock of that frame. A `clk_off` seen while the block is idle is discarded.
- R11: `soft_rst` forces the block idle on the next clock and discards any pending stop request.
- R12: `mclk_gate_en` equals `cfg_mclk_out` delayed by one master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_on | input | 1 | Start pulse for the bit and frame clocks |
| clk_off | input | 1 | Stop request pulse; takes effect at the frame end |
| soft_rst | input | 1 | Synchronous return to idle |
| cfg_fmt | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 TDM, 3 left-justified TDM |
| cfg_chan_m1 | input | CH_W | TDM slot count minus one |
| cfg_sync_shape | input | 2 | TDM frame-sync length: 0 slot, 1 half frame, 2 one bit |
| cfg_slot_sel | input | 1 | Slot width select: 0 = 32, 1 = 24 bit periods |
| cfg_ratio | input | RATIO_W | Oversampling code N |
| cfg_mclk_out | input | 1 | Request for a master-clock output gate |
| bclk | output | 1 | Bit clock |
| wsel | output | 1 | Word select / frame sync |
| mclk_gate_en | output | 1 | Enable for an external master-clock output gate |
| slot_idx | output | CH_W | Current slot number |
| msb_strobe | output | 1 | One-clock pulse at the start of each MSB bit period |
| active | output | 1 | Clocks are running |
| cfg_err | output | 1 | Configuration cannot be divided evenly or is reserved |

## Verification
All of the timing comes from three nested counters: master clocks within a bit, bits within a slot, and slots within a frame. A wrong count at any level shows at the ports within one bit period. A broken inner counter distorts the `bclk` duty cycle. A broken bit counter moves `msb_strobe` off bit 0 or bit 1. A broken slot counter puts `wsel` and `slot_idx` out of step with the bench's independent position model within the first frame. A wrong stop or restart decision shows as `active` falling one or more frames away from the predicted clock, and that clock is checked exactly.

// File: rtl/aft_pkg.sv
package aft_pkg;

   typedef enum logic [1:0] {
      FMT_I2S    = 2'd0,
      FMT_LJ     = 2'd1,
      FMT_TDM    = 2'd2,
      FMT_TDM_LJ = 2'd3
   } aft_fmt_e;

   typedef enum logic [1:0] {
      SYNC_SLOT = 2'd0,
      SYNC_HALF = 2'd1,
      SYNC_BIT  = 2'd2,
      SYNC_RSVD = 2'd3
   } aft_sync_e;

   function automatic int unsigned aft_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/aft_cfg_decode.sv
module aft_cfg_decode
   import aft_pkg::*;
#(
   parameter int RATIO_W    = 6,
   parameter int CH_W       = 3,
   parameter int RATIO_UNIT = 16,
   parameter int SLOT_W_A   = 32,
   parameter int SLOT_W_B   = 24,
   parameter int DIV_W      = 11,
   parameter int LEN_W      = 6,
   parameter int NSL_W      = 4
) (
   input  logic [1:0]         fmt,
   input  logic [CH_W-1:0]    chan_m1,
   input  logic [1:0]         sync_shape,
   input  logic               slot_sel,
   input  logic [RATIO_W-1:0] ratio,
   output logic [DIV_W-1:0]   bit_div,
   output logic [LEN_W-1:0]   slot_len,
   output logic [NSL_W-1:0]   nslots,
   output logic [NSL_W-1:0]   half_slots,
   output logic               err
);

   logic [DIV_W-1:0] num;
   logic [DIV_W-1:0] quo [2];
   logic [DIV_W-1:0] rem [2];
   logic [DIV_W-1:0] rem_sel;
   logic [NSL_W-1:0] half_raw;

   assign num = (DIV_W'(ratio) + DIV_W'(1)) * DIV_W'(RATIO_UNIT);

   for (genvar gi = 0; gi < 2; gi++) begin : g_width
      localparam int SW = (gi == 0) ? SLOT_W_A : SLOT_W_B;
      assign quo[gi] = num / DIV_W'(SW);
      assign rem[gi] = num % DIV_W'(SW);
   end

   assign bit_div  = slot_sel ? quo[1] : quo[0];
   assign rem_sel  = slot_sel ? rem[1] : rem[0];
   assign slot_len = slot_sel ? LEN_W'(SLOT_W_B) : LEN_W'(SLOT_W_A);

   always_comb begin
      if (fmt[1]) nslots = NSL_W'(chan_m1) + NSL_W'(1);
      else        nslots = NSL_W'(2);
   end

   assign half_raw   = nslots >> 1;
   assign half_slots = (half_raw == '0) ? NSL_W'(1) : half_raw;

   assign err = (rem_sel != '0) || (bit_div < DIV_W'(2)) ||
                (fmt[1] && (aft_sync_e'(sync_shape) == SYNC_RSVD));

endmodule

// File: rtl/aft_seq.sv
module aft_seq #(
   parameter int CH_W  = 3,
   parameter int DIV_W = 11,
   parameter int BIT_W = 5,
   parameter int LEN_W = 6,
   parameter int NSL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             srst,
   input  logic             err,
   input  logic [DIV_W-1:0] bit_div,
   input  logic [LEN_W-1:0] slot_len,
   input  logic [NSL_W-1:0] nslots,
   output logic             run_n,
   output logic [DIV_W-1:0] div_n,
   output logic [BIT_W-1:0] bit_n,
   output logic [CH_W-1:0]  slot_n
);

   logic             run_q, stop_q, stop_nx;
   logic [DIV_W-1:0] div_q;
   logic [BIT_W-1:0] bit_q;
   logic [CH_W-1:0]  slot_q;
   logic             last_div, last_bit, last_slot, frame_end;

   assign last_div  = div_q >= (bit_div - DIV_W'(1));
   assign last_bit  = LEN_W'(bit_q) >= (slot_len - LEN_W'(1));
   assign last_slot = NSL_W'(slot_q) >= (nslots - NSL_W'(1));
   assign frame_end = last_div && last_bit && last_slot;

   always_comb begin
      run_n  = run_q;
      div_n  = div_q;
      bit_n  = bit_q;
      slot_n = slot_q;
      if (srst) begin
         run_n  = 1'b0;
         div_n  = '0;
         bit_n  = '0;
         slot_n = '0;
      end else if (!run_q) begin
         run_n  = start && !err;
         div_n  = '0;
         bit_n  = '0;
         slot_n = '0;
      end else if (frame_end && (stop_q || stop)) begin
         run_n  = 1'b0;
         div_n  = '0;
         bit_n  = '0;
         slot_n = '0;
      end else if (last_div) begin
         div_n = '0;
         if (last_bit) begin
            bit_n  = '0;
            slot_n = last_slot ? '0 : slot_q + CH_W'(1);
         end else begin
            bit_n = bit_q + BIT_W'(1);
         end
      end else begin
         div_n = div_q + DIV_W'(1);
      end
   end

   assign stop_nx = !srst && run_n && (stop_q || (run_q && stop));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         stop_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         slot_q <= '0;
      end else begin
         run_q  <= run_n;
         stop_q <= stop_nx;
         div_q  <= div_n;
         bit_q  <= bit_n;
         slot_q <= slot_n;
      end
   end

endmodule

// File: rtl/aft_shaper.sv
module aft_shaper
   import aft_pkg::*;
#(
   parameter int CH_W  = 3,
   parameter int DIV_W = 11,
   parameter int BIT_W = 5,
   parameter int NSL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt,
   input  logic [1:0]       sync_shape,
   input  logic [NSL_W-1:0] half_slots,
   input  logic [DIV_W-1:0] bit_div,
   input  logic             mclk_req,
   input  logic             run_n,
   input  logic [DIV_W-1:0] div_n,
   input  logic [BIT_W-1:0] bit_n,
   input  logic [CH_W-1:0]  slot_n,
   output logic             bclk,
   output logic             wsel,
   output logic             msb_strobe,
   output logic [CH_W-1:0]  slot_idx,
   output logic             active,
   output logic             mclk_gate_en
);

   logic             frame_ws, idle_ws, ws_d, bclk_d, msb_d;
   logic [DIV_W-1:0] high_from;
   logic [BIT_W-1:0] msb_bit;
   logic             first_slot;

   assign first_slot = (slot_n == '0);
   assign idle_ws    = (aft_fmt_e'(fmt) == FMT_I2S);
   assign high_from  = bit_div - (bit_div >> 1);
   assign msb_bit    = fmt[0] ? BIT_W'(0) : BIT_W'(1);

   always_comb begin
      unique case (aft_fmt_e'(fmt))
         FMT_I2S: frame_ws = !first_slot;
         FMT_LJ:  frame_ws = first_slot;
         default: begin
            unique case (aft_sync_e'(sync_shape))
               SYNC_SLOT: frame_ws = first_slot;
               SYNC_HALF: frame_ws = NSL_W'(slot_n) < half_slots;
               SYNC_BIT:  frame_ws = first_slot && (bit_n == '0);
               default:   frame_ws = 1'b0;
            endcase
         end
      endcase
   end

   assign ws_d   = run_n ? frame_ws : idle_ws;
   assign bclk_d = run_n && (div_n >= high_from);
   assign msb_d  = run_n && (div_n == '0) && (bit_n == msb_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk         <= 1'b0;
         wsel         <= 1'b1;
         msb_strobe   <= 1'b0;
         slot_idx     <= '0;
         active       <= 1'b0;
         mclk_gate_en <= 1'b0;
      end else begin
         bclk         <= bclk_d;
         wsel         <= ws_d;
         msb_strobe   <= msb_d;
         slot_idx     <= slot_n;
         active       <= run_n;
         mclk_gate_en <= mclk_req;
      end
   end

endmodule

// File: rtl/aud_frame_timer.sv
module aud_frame_timer
   import aft_pkg::*;
#(
   parameter int RATIO_W    = 6,
   parameter int CH_W       = 3,
   parameter int RATIO_UNIT = 16,
   parameter int SLOT_W_A   = 32,
   parameter int SLOT_W_B   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_on,
   input  logic               clk_off,
   input  logic               soft_rst,
   input  logic [1:0]         cfg_fmt,
   input  logic [CH_W-1:0]    cfg_chan_m1,
   input  logic [1:0]         cfg_sync_shape,
   input  logic               cfg_slot_sel,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               cfg_mclk_out,
   output logic               bclk,
   output logic               wsel,
   output logic               mclk_gate_en,
   output logic [CH_W-1:0]    slot_idx,
   output logic               msb_strobe,
   output logic               active,
   output logic               cfg_err
);

   localparam int MAX_SW = aft_max(SLOT_W_A, SLOT_W_B);
   localparam int DIV_W  = $clog2((2 ** RATIO_W) * RATIO_UNIT + 1);
   localparam int BIT_W  = $clog2(MAX_SW);
   localparam int LEN_W  = $clog2(MAX_SW + 1);
   localparam int NSL_W  = CH_W + 1;

   if (SLOT_W_A < 2 || SLOT_W_B < 2) begin : g_bad_slot
      $error("aud_frame_timer: slot widths must be at least 2");
   end
   if (CH_W < 1 || RATIO_W < 1 || RATIO_UNIT < 1) begin : g_bad_width
      $error("aud_frame_timer: CH_W, RATIO_W and RATIO_UNIT must be positive");
   end

   logic [DIV_W-1:0] bit_div, div_n;
   logic [LEN_W-1:0] slot_len;
   logic [NSL_W-1:0] nslots, half_slots;
   logic [BIT_W-1:0] bit_n;
   logic [CH_W-1:0]  slot_n;
   logic             run_n;

   aft_cfg_decode #(
      .RATIO_W(RATIO_W), .CH_W(CH_W), .RATIO_UNIT(RATIO_UNIT),
      .SLOT_W_A(SLOT_W_A), .SLOT_W_B(SLOT_W_B),
      .DIV_W(DIV_W), .LEN_W(LEN_W), .NSL_W(NSL_W)
   ) u_dec (
      .fmt(cfg_fmt), .chan_m1(cfg_chan_m1), .sync_shape(cfg_sync_shape),
      .slot_sel(cfg_slot_sel), .ratio(cfg_ratio),
      .bit_div(bit_div), .slot_len(slot_len), .nslots(nslots),
      .half_slots(half_slots), .err(cfg_err)
   );

   aft_seq #(
      .CH_W(CH_W), .DIV_W(DIV_W), .BIT_W(BIT_W), .LEN_W(LEN_W), .NSL_W(NSL_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(clk_on), .stop(clk_off),
      .srst(soft_rst), .err(cfg_err), .bit_div(bit_div),
      .slot_len(slot_len), .nslots(nslots),
      .run_n(run_n), .div_n(div_n), .bit_n(bit_n), .slot_n(slot_n)
   );

   aft_shaper #(
      .CH_W(CH_W), .DIV_W(DIV_W), .BIT_W(BIT_W), .NSL_W(NSL_W)
   ) u_shp (
      .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt), .sync_shape(cfg_sync_shape),
      .half_slots(half_slots), .bit_div(bit_div), .mclk_req(cfg_mclk_out),
      .run_n(run_n), .div_n(div_n), .bit_n(bit_n), .slot_n(slot_n),
      .bclk(bclk), .wsel(wsel), .msb_strobe(msb_strobe),
      .slot_idx(slot_idx), .active(active), .mclk_gate_en(mclk_gate_en)
   );

endmodule

// File: rtl/aft_checker.sv
module aft_checker #(
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            soft_rst,
   input logic            cfg_err,
   input logic [1:0]      cfg_fmt,
   input logic [CH_W-1:0] cfg_chan_m1,
   input logic            cfg_mclk_out,
   input logic            bclk,
   input logic            msb_strobe,
   input logic [CH_W-1:0] slot_idx,
   input logic            active,
   input logic            mclk_gate_en
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!bclk && !msb_strobe && (slot_idx == '0)));

   a_r2_msb_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      msb_strobe |-> !bclk);

   a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cfg_fmt[1] ? (slot_idx <= cfg_chan_m1) : (slot_idx <= CH_W'(1))));

   a_r8_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !active) |=> !active);

   a_r9_bclk_rise_when_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> active);

   a_r11_soft_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!active && !bclk));

   a_r12_mclk_gate_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mclk_gate_en == $past(cfg_mclk_out)));

endmodule

bind aud_frame_timer aft_checker #(.CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_err(cfg_err),
   .cfg_fmt(cfg_fmt), .cfg_chan_m1(cfg_chan_m1), .cfg_mclk_out(cfg_mclk_out),
   .bclk(bclk), .msb_strobe(msb_strobe), .slot_idx(slot_idx),
   .active(active), .mclk_gate_en(mclk_gate_en)
);

// File: tb/aud_frame_timer_tb.sv
module aud_frame_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_on = 1'b0, clk_off = 1'b0, soft_rst = 1'b0;
   logic [1:0] cfg_fmt = 2'd0;
   logic [2:0] cfg_chan_m1 = 3'd0;
   logic [1:0] cfg_sync_shape = 2'd0;
   logic       cfg_slot_sel = 1'b0;
   logic [5:0] cfg_ratio = 6'd3;
   logic       cfg_mclk_out = 1'b0;
   logic       bclk, wsel, mclk_gate_en, msb_strobe, active, cfg_err;
   logic [2:0] slot_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   aud_frame_timer u_dut (
      .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .clk_off(clk_off),
      .soft_rst(soft_rst), .cfg_fmt(cfg_fmt), .cfg_chan_m1(cfg_chan_m1),
      .cfg_sync_shape(cfg_sync_shape), .cfg_slot_sel(cfg_slot_sel),
      .cfg_ratio(cfg_ratio), .cfg_mclk_out(cfg_mclk_out),
      .bclk(bclk), .wsel(wsel), .mclk_gate_en(mclk_gate_en),
      .slot_idx(slot_idx), .msb_strobe(msb_strobe), .active(active),
      .cfg_err(cfg_err)
   );

   typedef struct packed {
      logic [1:0] fmt;
      logic [2:0] chm1;
      logic [1:0] shape;
      logic       ssel;
      logic [5:0] ratio;
      logic       err;
      logic [7:0] d;
      logic [7:0] w;
      logic [7:0] s;
   } vec_t;

   // expected bit period d, slot width w and slot count s come from R2-R4
   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 3'd5, 2'd0, 1'b0, 6'd3, 1'b0, 8'd2, 8'd32, 8'd2},
      '{2'd1, 3'd0, 2'd0, 1'b1, 6'd5, 1'b0, 8'd4, 8'd24, 8'd2},
      '{2'd2, 3'd3, 2'd0, 1'b0, 6'd3, 1'b0, 8'd2, 8'd32, 8'd4},
      '{2'd2, 3'd7, 2'd1, 1'b1, 6'd2, 1'b0, 8'd2, 8'd24, 8'd8},
      '{2'd3, 3'd2, 2'd2, 1'b0, 6'd5, 1'b0, 8'd3, 8'd32, 8'd3},
      '{2'd2, 3'd2, 2'd1, 1'b1, 6'd2, 1'b0, 8'd2, 8'd24, 8'd3},
      '{2'd2, 3'd0, 2'd1, 1'b0, 6'd3, 1'b0, 8'd2, 8'd32, 8'd1},
      '{2'd0, 3'd0, 2'd0, 1'b0, 6'd0, 1'b1, 8'd0, 8'd32, 8'd2},
      '{2'd1, 3'd0, 2'd0, 1'b0, 6'd1, 1'b1, 8'd1, 8'd32, 8'd2},
      '{2'd2, 3'd3, 2'd3, 1'b0, 6'd3, 1'b1, 8'd2, 8'd32, 8'd4},
      '{2'd0, 3'd0, 2'd0, 1'b1, 6'd3, 1'b1, 8'd2, 8'd24, 8'd2}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic string fmt_req(input logic [1:0] f);
      if (f == 2'd0) return "R5";
      if (f == 2'd1) return "R6";
      return "R7";
   endfunction

   // expected word select at (slot, bit) per R5 R6 R7
   function automatic logic exp_ws(input vec_t v, input int slot, input int b);
      int half;
      half = (v.s / 2 == 0) ? 1 : v.s / 2;
      case (v.fmt)
         2'd0: return slot != 0;
         2'd1: return slot == 0;
         default: begin
            if (v.shape == 2'd0) return slot == 0;
            if (v.shape == 2'd1) return slot < half;
            return (slot == 0) && (b == 0);
         end
      endcase
   endfunction

   task automatic apply_cfg(input vec_t v);
      cfg_fmt = v.fmt; cfg_chan_m1 = v.chm1; cfg_sync_shape = v.shape;
      cfg_slot_sel = v.ssel; cfg_ratio = v.ratio;
   endtask

   task automatic run_vec(input vec_t v);
      int f, d, w, s;
      bit bad_b, bad_w, bad_m, bad_s, bad_a;
      d = int'(v.d); w = int'(v.w); s = int'(v.s);
      f = d * w * s;
      bad_b = 0; bad_w = 0; bad_m = 0; bad_s = 0; bad_a = 0;
      apply_cfg(v);
      tick();
      check(cfg_err == v.err, "R8", "cfg_err", int'(cfg_err), int'(v.err));
      if (v.err) begin
         clk_on = 1'b1; tick(); clk_on = 1'b0;
         repeat (3) tick();
         check(!active && !bclk, "R8", "start refused, active", int'(active), 0);
         return;
      end
      clk_on = 1'b1; tick(); clk_on = 1'b0;
      for (int k = 0; k <= 2 * f; k++) begin
         if (k < 2 * f) begin
            int dv, bt, sl;
            logic eb, ew, em;
            dv = k % d; bt = (k / d) % w; sl = (k / (d * w)) % s;
            eb = dv >= (d - d / 2);
            ew = exp_ws(v, sl, bt);
            em = (dv == 0) && (bt == (v.fmt[0] ? 0 : 1));
            if (bclk !== eb && !bad_b) begin
               bad_b = 1; check(0, "R2 R3", $sformatf("bclk at %0d", k), int'(bclk), int'(eb));
            end
            if (wsel !== ew && !bad_w) begin
               bad_w = 1; check(0, fmt_req(v.fmt), $sformatf("wsel at %0d", k), int'(wsel), int'(ew));
            end
            if (msb_strobe !== em && !bad_m) begin
               bad_m = 1; check(0, fmt_req(v.fmt), $sformatf("msb at %0d", k), int'(msb_strobe), int'(em));
            end
            if (int'(slot_idx) != sl && !bad_s) begin
               bad_s = 1; check(0, "R4", $sformatf("slot at %0d", k), int'(slot_idx), sl);
            end
            if (active !== 1'b1 && !bad_a) begin
               bad_a = 1; check(0, "R9 R10", $sformatf("active at %0d", k), int'(active), 1);
            end
         end else begin
            check(!active && !bclk, "R10", "parked after frame end", int'(active), 0);
            check(wsel == (v.fmt == 2'd0), "R1", "idle wsel", int'(wsel), int'(v.fmt == 2'd0));
         end
         clk_on  = (k == f + 1);   // R9: restart while running is ignored
         clk_off = (k == f + 3);
         tick();
      end
      clk_on = 1'b0; clk_off = 1'b0;
      if (!bad_b) check(1, "R2 R3", "bclk", 0, 0);
      if (!bad_w) check(1, fmt_req(v.fmt), "wsel", 0, 0);
      if (!bad_m) check(1, fmt_req(v.fmt), "msb", 0, 0);
      if (!bad_s) check(1, "R4", "slot", 0, 0);
      if (!bad_a) check(1, "R9 R10", "active", 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(0, "watchdog", "run did not finish", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int f0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check(!active && !bclk && !msb_strobe && slot_idx == 3'd0, "R1", "reset outputs", int'(active), 0);
      check(wsel == 1'b1, "R1", "reset wsel for format 0", int'(wsel), 1);
      check(!cfg_err, "R8", "default cfg legal", int'(cfg_err), 0);

      // R12 master-clock gate follows the request one clock later
      cfg_mclk_out = 1'b1; tick();
      check(mclk_gate_en == 1'b1, "R12", "gate on", int'(mclk_gate_en), 1);
      cfg_mclk_out = 1'b0; tick();
      check(mclk_gate_en == 1'b0, "R12", "gate off", int'(mclk_gate_en), 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R10: stop while idle is discarded
      apply_cfg(VECS[0]);
      f0 = 2 * 32 * 2;
      clk_off = 1'b1; tick(); clk_off = 1'b0; tick();
      clk_on = 1'b1; tick(); clk_on = 1'b0;
      for (int k = 0; k < f0 + 2; k++) tick();
      check(active == 1'b1, "R10", "idle stop discarded", int'(active), 1);

      // R11: soft reset idles at once
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      check(!active && !bclk && wsel, "R11", "idle after soft reset", int'(active), 0);

      // R11: pending stop discarded by soft reset
      clk_on = 1'b1; tick(); clk_on = 1'b0;
      for (int k = 0; k < 10; k++) tick();
      clk_off = 1'b1; tick(); clk_off = 1'b0;
      for (int k = 0; k < 10; k++) tick();
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      check(!active, "R11", "soft reset mid frame", int'(active), 0);
      clk_on = 1'b1; tick(); clk_on = 1'b0;
      for (int k = 0; k < f0 + 2; k++) tick();
      check(active == 1'b1, "R11", "stale stop discarded", int'(active), 1);
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule